// File: doc/BRIEF.md
# USB Host Controller Register File

This block is the 32-byte I/O register window of a two-port full/low-speed USB host controller. Software reaches it with byte, word and dword accesses at fixed offsets. The window holds the command word, the status word, the interrupt-enable word, the frame number, the frame-list base address, the start-of-frame timing byte and one status/control word per root port. Schedule processing and device behaviour sit outside the block. That logic reports its events to the block as single-cycle set pulses: transfer-interrupt causes, errors, resume, system faults, halt, and device attach or detach with the device speed.

The status word uses write-one-to-clear semantics. A hidden two-bit cause register separates completion interrupts from short-packet interrupts, so that each can be enabled on its own. The block combines these sources into one level-sensitive interrupt line. It also drives a one-cycle reset pulse toward each attached device when software starts a port reset or a global reset.

Top module: `usbh_regfile`

## Requirements
- R1: After the asynchronous reset, every port word reads 0x0080, the timing byte reads 64, and the command, status, enable, frame-number and base registers read zero.
- R2: Read data appears on rdata_o on the clock edge that samples rd_en_i and is held until the next read. acc_size_i encodes 0 for byte, 1 for word and 2 for dword. The following reads return fixed fill values: a word read of an unmapped offset, or of port slots 2 to 7 (0x14 to 0x1E), returns 0x0000FF7F. A dword read at any offset except 0x08 returns 0xFFFFFFFF. A byte read at any offset except 0x0C returns 0x000000FF.
- R3: A word write to offset 0x00 stores the written value, where bit 0 is run, bit 1 is controller reset and bit 2 is global reset. Exception: when written bit 2 is 1, the value is not stored. Instead, all registers return to their R1 defaults, any event pulses in that cycle are dropped, every attached port gets one reset pulse, and every attached port then shows connect status and connect change, plus its low-speed bit.
- R4: A word write to offset 0x02 clears each status bit whose written bit is 1. When written bit 0 is 1, it also clears both hidden cause bits. An event pulse in the same cycle takes priority over the clear.
- R5: ev_cause_i[0] (completion) and ev_cause_i[1] (short packet) each set their hidden cause bit and status bit 0. The other event inputs set these status bits: ev_err_i bit 1, ev_resume_i bit 2, ev_hse_i bit 3, ev_perr_i bit 4, ev_halt_i bit 5.
- R6: irq_o is high when any of these holds: cause 0 with enable bit 2, cause 1 with enable bit 3, status bit 1 with enable bit 0, status bit 2 with enable bit 1, status bit 3, or status bit 4. The enable word sits at word offset 0x04.
- R7: A word write to offset 0x06 stores the low 11 bits as the frame number only while status bit 5 (halted) is set. Otherwise it has no effect.
- R8: A dword write to offset 0x08 stores the base address with its low 12 bits forced to zero. A byte write to offset 0x0C stores the timing byte.
- R9: A word write to port slot n (offset 0x10 + 2n) takes new bits from the data where the mask 0x01FB is zero and keeps old bits where it is one. It then clears bit 1 (connect change) and bit 3 (enable change) wherever the data has a 1. Bit 0 is connect status, bit 2 is enable, bit 8 is low speed and bit 9 is port reset.
- R10: A port write that moves bit 9 from 0 to 1 while a device is attached drives dev_reset_o[n] high for exactly one cycle. No pulse occurs if bit 9 was already 1 or no device is attached.
- R11: An attach pulse sets connect status and connect change if connect status was clear, and sets bit 8 from port_lowspd_i. A detach pulse with enable set clears enable and sets enable change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_addr_i | input | 5 | Byte address within the window |
| acc_size_i | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data, right-aligned |
| rdata_o | output | 32 | Registered read data |
| ev_cause_i | input | 2 | Set pulses for completion and short-packet causes |
| ev_err_i | input | 1 | Set pulse for transfer error |
| ev_resume_i | input | 1 | Set pulse for resume detect |
| ev_hse_i | input | 1 | Set pulse for host system error |
| ev_perr_i | input | 1 | Set pulse for process error |
| ev_halt_i | input | 1 | Set pulse for halted |
| port_attach_i | input | NPORT | Per-port device attach pulse |
| port_detach_i | input | NPORT | Per-port device detach pulse |
| port_lowspd_i | input | NPORT | Speed of the attaching device, 1 = low speed |
| dev_reset_o | output | NPORT | One-cycle reset pulse toward each device |
| irq_o | output | 1 | Level interrupt line |

## Verification
A write or an event pulse changes register state on the edge that samples it. irq_o follows from that state without further delay. dev_reset_o is registered, so it is high in the cycle right after the write edge and low again one cycle later. A read returns data on the edge that samples rd_en_i. The bench drives every stimulus for one cycle starting at a falling edge and samples at the next falling edge, which is the first point where each of these results is due. For the reset pulse it also samples one cycle later to confirm the pulse has ended.

// File: rtl/usbh_pkg.sv
package usbh_pkg;
  localparam int AW      = 5;
  localparam int DW      = 32;
  localparam int RW      = 16;
  localparam int BW      = 8;
  localparam int STW     = 6;
  localparam int CAUSEW  = 2;
  localparam int FNW     = 11;
  localparam int FLB_LOW = 12;
  localparam int SLOTW   = 3;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } acc_sz_e;

  localparam logic [AW-1:0] OFS_CMD  = 5'h00;
  localparam logic [AW-1:0] OFS_STS  = 5'h02;
  localparam logic [AW-1:0] OFS_IE   = 5'h04;
  localparam logic [AW-1:0] OFS_FRN  = 5'h06;
  localparam logic [AW-1:0] OFS_FLB  = 5'h08;
  localparam logic [AW-1:0] OFS_SOF  = 5'h0C;

  localparam logic [RW-1:0] PORT_RST_VAL = 16'h0080;
  localparam logic [RW-1:0] PORT_KEEP    = 16'h01FB;
  localparam logic [RW-1:0] PORT_W1C     = 16'h000A;
  localparam logic [BW-1:0] SOF_RST_VAL  = 8'd64;
  localparam logic [RW-1:0] FILL_WORD    = 16'hFF7F;
  localparam logic [BW-1:0] FILL_BYTE    = 8'hFF;

  localparam int PB_CCS = 0;
  localparam int PB_CSC = 1;
  localparam int PB_EN  = 2;
  localparam int PB_ENC = 3;
  localparam int PB_LS  = 8;
  localparam int PB_RST = 9;

  localparam int CB_GRST = 2;
  localparam int SB_INT  = 0;
  localparam int SB_HALT = 5;
endpackage

// File: rtl/usbh_irq_merge.sv
module usbh_irq_merge
  import usbh_pkg::*;
(
  input  logic [STW-1:0]    sts_i,
  input  logic [RW-1:0]     ie_i,
  input  logic [CAUSEW-1:0] cause_i,
  output logic              irq_o
);
  // error/resume gated by enable 0/1, causes by enable 2/3, faults ungated
  assign irq_o = (cause_i[0] & ie_i[2]) | (cause_i[1] & ie_i[3]) |
                 (sts_i[1] & ie_i[0])   | (sts_i[2] & ie_i[1])   |
                 sts_i[3] | sts_i[4];
endmodule

// File: rtl/usbh_core_regs.sv
module usbh_core_regs
  import usbh_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     acc_addr_i,
  input  logic [1:0]        acc_size_i,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [CAUSEW-1:0] ev_cause_i,
  input  logic              ev_err_i,
  input  logic              ev_resume_i,
  input  logic              ev_hse_i,
  input  logic              ev_perr_i,
  input  logic              ev_halt_i,
  output logic              grst_o,
  output logic [RW-1:0]     cmd_o,
  output logic [STW-1:0]    sts_o,
  output logic [RW-1:0]     ie_o,
  output logic [FNW-1:0]    frnum_o,
  output logic [DW-1:0]     flbase_o,
  output logic [BW-1:0]     sof_o,
  output logic [CAUSEW-1:0] cause_o
);
  logic wr_word, wr_cmd, wr_sts, wr_ie, wr_frn, wr_flb, wr_sof;
  logic [STW-1:0]    sts_set, sts_clr;
  logic [DW-FLB_LOW-1:0] flb_q;

  assign wr_word = wr_en_i && (acc_size_i == SZ_WORD);
  assign wr_cmd  = wr_word && (acc_addr_i == OFS_CMD);
  assign wr_sts  = wr_word && (acc_addr_i == OFS_STS);
  assign wr_ie   = wr_word && (acc_addr_i == OFS_IE);
  assign wr_frn  = wr_word && (acc_addr_i == OFS_FRN);
  assign wr_flb  = wr_en_i && (acc_size_i == SZ_DWORD) && (acc_addr_i == OFS_FLB);
  assign wr_sof  = wr_en_i && (acc_size_i == SZ_BYTE) && (acc_addr_i == OFS_SOF);
  assign grst_o  = wr_cmd && wdata_i[CB_GRST];

  assign sts_set = {ev_halt_i, ev_perr_i, ev_hse_i, ev_resume_i, ev_err_i, |ev_cause_i};
  assign sts_clr = wr_sts ? wdata_i[STW-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o   <= '0;
      sts_o   <= '0;
      ie_o    <= '0;
      frnum_o <= '0;
      flb_q   <= '0;
      sof_o   <= SOF_RST_VAL;
      cause_o <= '0;
    end else if (grst_o) begin
      cmd_o   <= '0;
      sts_o   <= '0;
      ie_o    <= '0;
      frnum_o <= '0;
      flb_q   <= '0;
      sof_o   <= SOF_RST_VAL;
      cause_o <= '0;
    end else begin
      if (wr_cmd) cmd_o <= wdata_i[RW-1:0];
      sts_o <= (sts_o & ~sts_clr) | sts_set;
      cause_o <= ((wr_sts && wdata_i[SB_INT]) ? '0 : cause_o) | ev_cause_i;
      if (wr_ie) ie_o <= wdata_i[RW-1:0];
      if (wr_frn && sts_o[SB_HALT]) frnum_o <= wdata_i[FNW-1:0];
      if (wr_flb) flb_q <= wdata_i[DW-1:FLB_LOW];
      if (wr_sof) sof_o <= wdata_i[BW-1:0];
    end
  end

  assign flbase_o = {flb_q, {FLB_LOW{1'b0}}};
endmodule

// File: rtl/usbh_port_reg.sv
module usbh_port_reg
  import usbh_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          grst_i,
  input  logic          wr_i,
  input  logic [RW-1:0] wdata_i,
  input  logic          attach_i,
  input  logic          detach_i,
  input  logic          lowspd_i,
  output logic [RW-1:0] ctrl_o,
  output logic          dev_rst_o
);
  logic          present_q, low_q;
  logic [RW-1:0] after_wr, ctrl_d, grst_val;
  logic          rst_rise;

  assign rst_rise = wr_i && wdata_i[PB_RST] && !ctrl_o[PB_RST];

  always_comb begin
    after_wr = ctrl_o;
    if (wr_i) after_wr = ((ctrl_o & PORT_KEEP) | (wdata_i & ~PORT_KEEP)) & ~(wdata_i & PORT_W1C);
    ctrl_d = after_wr;
    if (attach_i) begin
      if (!after_wr[PB_CCS]) begin
        ctrl_d[PB_CCS] = 1'b1;
        ctrl_d[PB_CSC] = 1'b1;
      end
      ctrl_d[PB_LS] = lowspd_i;
    end
    if (detach_i && ctrl_d[PB_EN]) begin
      ctrl_d[PB_EN]  = 1'b0;
      ctrl_d[PB_ENC] = 1'b1;
    end
  end

  // defaults, then attach re-applied for a device still on the port
  always_comb begin
    grst_val = PORT_RST_VAL;
    if (present_q) begin
      grst_val[PB_CCS] = 1'b1;
      grst_val[PB_CSC] = 1'b1;
      grst_val[PB_LS]  = low_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o    <= PORT_RST_VAL;
      present_q <= 1'b0;
      low_q     <= 1'b0;
      dev_rst_o <= 1'b0;
    end else if (grst_i) begin
      ctrl_o    <= grst_val;
      dev_rst_o <= present_q;
    end else begin
      ctrl_o    <= ctrl_d;
      dev_rst_o <= present_q && rst_rise;
      if (attach_i) begin
        present_q <= 1'b1;
        low_q     <= lowspd_i;
      end else if (detach_i) begin
        present_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/usbh_regfile.sv
module usbh_regfile
  import usbh_pkg::*;
#(
  parameter int NPORT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     acc_addr_i,
  input  logic [1:0]        acc_size_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [CAUSEW-1:0] ev_cause_i,
  input  logic              ev_err_i,
  input  logic              ev_resume_i,
  input  logic              ev_hse_i,
  input  logic              ev_perr_i,
  input  logic              ev_halt_i,
  input  logic [NPORT-1:0]  port_attach_i,
  input  logic [NPORT-1:0]  port_detach_i,
  input  logic [NPORT-1:0]  port_lowspd_i,
  output logic [NPORT-1:0]  dev_reset_o,
  output logic              irq_o
);
  localparam int NSLOT = 1 << SLOTW;

  logic              grst_w;
  logic [RW-1:0]     cmd_w, ie_w;
  logic [STW-1:0]    sts_w;
  logic [FNW-1:0]    frnum_w;
  logic [DW-1:0]     flbase_w;
  logic [BW-1:0]     sof_w;
  logic [CAUSEW-1:0] cause_w;
  logic [RW-1:0]     port_ctrl [NPORT];
  logic [SLOTW-1:0]  slot;
  logic              port_area;
  logic [RW-1:0]     port_rd, word_rd;
  logic [DW-1:0]     rd_d;

  assign slot      = acc_addr_i[SLOTW:1];
  assign port_area = acc_addr_i[AW-1];

  usbh_core_regs u_core (
    .clk_i, .rst_ni, .acc_addr_i, .acc_size_i, .wr_en_i, .wdata_i,
    .ev_cause_i, .ev_err_i, .ev_resume_i, .ev_hse_i, .ev_perr_i, .ev_halt_i,
    .grst_o(grst_w), .cmd_o(cmd_w), .sts_o(sts_w), .ie_o(ie_w),
    .frnum_o(frnum_w), .flbase_o(flbase_w), .sof_o(sof_w), .cause_o(cause_w)
  );

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    logic wr_slot;
    assign wr_slot = wr_en_i && (acc_size_i == SZ_WORD) && port_area && (slot == SLOTW'(i));
    usbh_port_reg u_port (
      .clk_i, .rst_ni, .grst_i(grst_w), .wr_i(wr_slot), .wdata_i(wdata_i[RW-1:0]),
      .attach_i(port_attach_i[i]), .detach_i(port_detach_i[i]),
      .lowspd_i(port_lowspd_i[i]), .ctrl_o(port_ctrl[i]), .dev_rst_o(dev_reset_o[i])
    );
  end

  usbh_irq_merge u_irq (.sts_i(sts_w), .ie_i(ie_w), .cause_i(cause_w), .irq_o);

  always_comb begin
    port_rd = FILL_WORD;
    for (int i = 0; i < NPORT; i++)
      if (i < NSLOT && slot == SLOTW'(i)) port_rd = port_ctrl[i];
  end

  always_comb begin
    if (port_area) word_rd = port_rd;
    else begin
      case (acc_addr_i)
        OFS_CMD: word_rd = cmd_w;
        OFS_STS: word_rd = RW'(sts_w);
        OFS_IE:  word_rd = ie_w;
        OFS_FRN: word_rd = RW'(frnum_w);
        default: word_rd = FILL_WORD;
      endcase
    end
  end

  always_comb begin
    case (acc_size_i)
      SZ_BYTE:  rd_d = DW'((acc_addr_i == OFS_SOF) ? sof_w : FILL_BYTE);
      SZ_WORD:  rd_d = DW'(word_rd);
      SZ_DWORD: rd_d = (acc_addr_i == OFS_FLB) ? flbase_w : '1;
      default:  rd_d = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_d;
  end
endmodule

// File: rtl/usbh_regfile_chk.sv
module usbh_regfile_chk
  import usbh_pkg::*;
#(
  parameter int NPORT = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AW-1:0]    acc_addr_i,
  input logic [1:0]       acc_size_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [DW-1:0]    wdata_i,
  input logic [DW-1:0]    rdata_o,
  input logic             ev_err_i,
  input logic [NPORT-1:0] dev_reset_o,
  input logic             irq_o,
  input logic [STW-1:0]   sts_w,
  input logic [FNW-1:0]   frnum_w
);
  logic grst_wr;
  assign grst_wr = wr_en_i && (acc_size_i == SZ_WORD) && (acc_addr_i == OFS_CMD) && wdata_i[CB_GRST];

  a_r5_err_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_err_i && !grst_wr |=> sts_w[1]);

  a_r6_hse_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_w[3] |-> irq_o);

  a_r6_perr_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_w[4] |-> irq_o);

  a_r7_frnum_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_w[SB_HALT] && !grst_wr |=> $stable(frnum_w));

  a_r2_unmapped_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && acc_size_i == SZ_WORD && acc_addr_i == 5'h0A |=> rdata_o == 32'h0000FF7F);

  a_r8_flbase_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && acc_size_i == SZ_DWORD && acc_addr_i == OFS_FLB |=> rdata_o[FLB_LOW-1:0] == '0);

  a_r10_pulse_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_reset_o != '0) |-> $past(wr_en_i));
endmodule

bind usbh_regfile usbh_regfile_chk #(.NPORT(NPORT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .acc_addr_i(acc_addr_i), .acc_size_i(acc_size_i),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .ev_err_i(ev_err_i), .dev_reset_o(dev_reset_o), .irq_o(irq_o),
  .sts_w(sts_w), .frnum_w(frnum_w)
);

// File: tb/sim_usbh_regfile.sv
`timescale 1ns/1ps
module sim_usbh_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic [1:0]  size = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  ev_cause = '0;
  logic        ev_err = 0, ev_resume = 0, ev_hse = 0, ev_perr = 0, ev_halt = 0;
  logic [1:0]  attach = '0, detach = '0, lowspd = '0;
  logic [1:0]  dev_reset;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  usbh_regfile #(.NPORT(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .acc_addr_i(addr), .acc_size_i(size),
    .wr_en_i(wr), .rd_en_i(rd), .wdata_i(wdata), .rdata_o(rdata),
    .ev_cause_i(ev_cause), .ev_err_i(ev_err), .ev_resume_i(ev_resume),
    .ev_hse_i(ev_hse), .ev_perr_i(ev_perr), .ev_halt_i(ev_halt),
    .port_attach_i(attach), .port_detach_i(detach), .port_lowspd_i(lowspd),
    .dev_reset_o(dev_reset), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr_acc(input logic [1:0] sz, input logic [4:0] a, input logic [31:0] d);
    size = sz; addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_acc(input logic [1:0] sz, input logic [4:0] a, output logic [31:0] d);
    size = sz; addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic ev_pulse(input int k);
    case (k)
      0: ev_cause = 2'b01;
      1: ev_cause = 2'b10;
      2: ev_err = 1'b1;
      3: ev_resume = 1'b1;
      4: ev_hse = 1'b1;
      5: ev_perr = 1'b1;
      default: ev_halt = 1'b1;
    endcase
    @(negedge clk);
    ev_cause = '0; ev_err = 0; ev_resume = 0; ev_hse = 0; ev_perr = 0; ev_halt = 0;
  endtask

  task automatic port_ev(input int p, input bit att, input bit low);
    if (att) attach[p] = 1'b1; else detach[p] = 1'b1;
    lowspd[p] = low;
    @(negedge clk);
    attach = '0; detach = '0;
  endtask

  function automatic logic [15:0] port_model(input logic [15:0] old, input logic [15:0] w);
    logic [15:0] v;
    v = (old & 16'h01FB) | (w & 16'hFE04);
    return v & ~(w & 16'h000A);
  endfunction

  function automatic bit irq_model(input int src, input logic [3:0] ie);
    case (src)
      0: return ie[2];
      1: return ie[3];
      2: return ie[0];
      3: return ie[1];
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    logic [31:0] d;
    logic [15:0] p1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 defaults
    rd_acc(1, 5'h00, d); chk("R1 cmd", d, 0);
    rd_acc(1, 5'h02, d); chk("R1 sts", d, 0);
    rd_acc(1, 5'h04, d); chk("R1 ie", d, 0);
    rd_acc(1, 5'h06, d); chk("R1 frnum", d, 0);
    rd_acc(2, 5'h08, d); chk("R1 flbase", d, 0);
    rd_acc(0, 5'h0C, d); chk("R1 sof", d, 64);
    rd_acc(1, 5'h10, d); chk("R1 port0", d, 32'h80);
    rd_acc(1, 5'h12, d); chk("R1 port1", d, 32'h80);

    // R2 fill values
    rd_acc(1, 5'h0A, d); chk("R2 unmapped word", d, 32'hFF7F);
    for (int s = 2; s < 8; s++) begin
      rd_acc(1, 5'(16 + 2*s), d); chk("R2 empty slot", d, 32'hFF7F);
    end
    rd_acc(2, 5'h00, d); chk("R2 unmapped dword", d, 32'hFFFFFFFF);
    rd_acc(0, 5'h00, d); chk("R2 unmapped byte", d, 32'hFF);

    // R5 each event sets its status bit
    for (int k = 0; k < 7; k++) begin
      wr_acc(1, 5'h02, 32'h3F);
      ev_pulse(k);
      rd_acc(1, 5'h02, d);
      chk("R5 status bit", d, 32'(1 << (k < 2 ? 0 : k - 1)));
    end
    wr_acc(1, 5'h02, 32'h3F);

    // R6 interrupt sweep over enable word and sources
    for (int ie = 0; ie < 16; ie++) begin
      for (int src = 0; src < 6; src++) begin
        wr_acc(1, 5'h02, 32'h3F);
        wr_acc(1, 5'h04, 32'(ie));
        ev_pulse(src);
        chk("R6 irq", 32'(irq), 32'(irq_model(src, 4'(ie))));
      end
    end
    wr_acc(1, 5'h02, 32'h3F);
    chk("R6 irq idle", 32'(irq), 0);

    // R4 clearing rules
    wr_acc(1, 5'h04, 32'h000C);
    ev_pulse(1);
    ev_pulse(2);
    wr_acc(1, 5'h02, 32'h0002);
    rd_acc(1, 5'h02, d); chk("R4 partial clear", d, 32'h1);
    chk("R4 cause kept", 32'(irq), 1);
    wr_acc(1, 5'h02, 32'h0001);
    rd_acc(1, 5'h02, d); chk("R4 bit0 clear", d, 0);
    chk("R4 cause cleared", 32'(irq), 0);
    size = 1; addr = 5'h02; wdata = 32'h1; wr = 1'b1; ev_err = 1'b1;
    @(negedge clk);
    wr = 1'b0; ev_err = 1'b0;
    rd_acc(1, 5'h02, d); chk("R4 set beats clear", d, 32'h2);
    wr_acc(1, 5'h02, 32'h3F);
    wr_acc(1, 5'h04, 32'h0);

    // R7 frame number
    ev_pulse(6);
    wr_acc(1, 5'h06, 32'hFFFF);
    rd_acc(1, 5'h06, d); chk("R7 halted write", d, 32'h7FF);
    wr_acc(1, 5'h02, 32'h20);
    wr_acc(1, 5'h06, 32'h0123);
    rd_acc(1, 5'h06, d); chk("R7 running write ignored", d, 32'h7FF);

    // R8 base and timing
    wr_acc(2, 5'h08, 32'hDEADBEEF);
    rd_acc(2, 5'h08, d); chk("R8 flbase", d, 32'hDEADB000);
    wr_acc(0, 5'h0C, 32'h5A);
    rd_acc(0, 5'h0C, d); chk("R8 sof", d, 32'h5A);

    // R11 attach
    port_ev(0, 1, 1);
    port_ev(1, 1, 0);
    rd_acc(1, 5'h10, d); chk("R11 attach low", d, 32'h0183);
    rd_acc(1, 5'h12, d); chk("R11 attach full", d, 32'h0083);

    // R9 port write sweep on port 1
    p1 = 16'h0083;
    for (int i = 0; i < 40; i++) begin
      logic [15:0] w;
      w = 16'(i * 16'h0B3D) ^ 16'h5A00;
      wr_acc(1, 5'h12, {16'h0, w});
      p1 = port_model(p1, w);
      rd_acc(1, 5'h12, d); chk("R9 port write", d, {16'h0, p1});
    end

    // R10 reset pulses
    wr_acc(1, 5'h12, 32'h0000); p1 = port_model(p1, 16'h0000);
    wr_acc(1, 5'h12, 32'h0200); p1 = port_model(p1, 16'h0200);
    chk("R10 pulse", 32'(dev_reset), 32'h2);
    @(negedge clk);
    chk("R10 pulse ends", 32'(dev_reset), 0);
    wr_acc(1, 5'h12, 32'h0200); p1 = port_model(p1, 16'h0200);
    chk("R10 no pulse when set", 32'(dev_reset), 0);

    // R11 detach with enable, attach with connect already set
    wr_acc(1, 5'h12, 32'h0004); p1 = port_model(p1, 16'h0004);
    port_ev(1, 0, 0);
    p1 = (p1 & ~16'h0004) | 16'h0008;
    rd_acc(1, 5'h12, d); chk("R11 detach", d, {16'h0, p1});
    wr_acc(1, 5'h12, 32'h0002); p1 = port_model(p1, 16'h0002);
    port_ev(1, 1, 1);
    p1 = p1 | 16'h0100;
    if (!p1[0]) p1 = p1 | 16'h0003;
    rd_acc(1, 5'h12, d); chk("R11 reattach", d, {16'h0, p1});
    port_ev(1, 0, 0);
    wr_acc(1, 5'h12, 32'h0000);
    wr_acc(1, 5'h12, 32'h0200);
    chk("R10 no pulse detached", 32'(dev_reset), 0);

    // R3 command and global reset
    port_ev(1, 1, 0);
    wr_acc(1, 5'h00, 32'h0003);
    rd_acc(1, 5'h00, d); chk("R3 cmd store", d, 32'h3);
    wr_acc(1, 5'h04, 32'h000F);
    wr_acc(1, 5'h00, 32'h0005);
    chk("R3 reset pulses", 32'(dev_reset), 32'h3);
    rd_acc(1, 5'h00, d); chk("R3 cmd not stored", d, 0);
    rd_acc(1, 5'h04, d); chk("R3 ie default", d, 0);
    rd_acc(2, 5'h08, d); chk("R3 flbase default", d, 0);
    rd_acc(0, 5'h0C, d); chk("R3 sof default", d, 64);
    rd_acc(1, 5'h10, d); chk("R3 port0 reattach", d, 32'h0183);
    rd_acc(1, 5'h12, d); chk("R3 port1 reattach", d, 32'h0083);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule